// File: doc/BRIEF.md
# Field-Oriented Control Stage Sequencer

This block is the control and status logic of a seven-stage motor-control accelerator. The stages run in a fixed pipeline order: Clarke transform (stage 0), Park transform (1), d-axis PI controller (2), q-axis PI controller (3), inverse Park (4), inverse Clarke (5) and space-vector PWM (6). The arithmetic of the stages lives elsewhere. This block sends each stage a one-cycle start pulse, or a one-cycle abort pulse when software cancels it. It receives a one-cycle done pulse back from each stage, and a PWM-load pulse from the last stage once that stage has reloaded the PWM duty registers.

Software uses two 32-bit registers through a simple write port, and both registers are always visible on read-data outputs. In the control register, bits 0..6 are self-clearing start bits, indexed by stage number, and they always read as zero. Bits 9..14 let stages 1..6 start automatically when their predecessor completes, so a single start of stage 0 can run the whole chain. The status register holds a sticky completion flag for each stage. A flag is cleared by writing one to it, or automatically after the PWM reload when automatic clearing is enabled. A level interrupt combines the flags with per-stage enables behind a global enable.

Top module: `foc_seq_ctrl`

## Requirements
- R1: After reset, all pulse outputs, `irq`, `ctrl_rdata` and `stat_rdata` are zero, and no stage is running.
- R2: A control write with bit i (0..6) set starts stage i. `stg_start[i]` is high for exactly the one cycle that follows the write cycle, and bit i of `ctrl_rdata` stays zero.
- R3: A control write with bit i clear while stage i is running (started and not yet done) produces a one-cycle `stg_abort[i]` in the following cycle and cancels the stage. A later done pulse for that stage is then ignored.
- R4: A done pulse on `stg_done[i]` while stage i is running sets flag i (`stat_rdata[i]`) from the next cycle and ends the run. A done pulse for a stage that is not running changes nothing.
- R5: When the auto bit of stage i (control bit 8+i, i = 1..6) is set, an accepted done of stage i-1 produces `stg_start[i]` in the next cycle, the same cycle in which flag i-1 rises.
- R6: With its auto bit clear, a stage is never started by its predecessor's completion.
- R7: A status write clears every flag whose bit 0..6 is one and leaves the other flags unchanged. A done that sets the same flag in the same cycle takes priority, and the flag ends up set.
- R8: With control bit 16 set, a `pwm_load` pulse clears the flags of those stages 1..6 whose auto bit is set, from the next cycle. The flag of stage 0 and the flags of non-auto stages are kept.
- R9: With control bit 17 set, stage 6 ignores both a software start and an automatic start.
- R10: `irq` equals control bit 31 AND the OR over i of (flag i AND control bit 24+i). It is a level that follows the flags and the control bits with no added delay.
- R11: `ctrl_rdata` returns the stored auto bits (9..14), bit 16, bit 17 and bits 24..31 at their positions. All other bits read zero. `stat_rdata` bits 7..31 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the control register, 1 the status register |
| reg_wdata | input | 32 | Write data |
| ctrl_rdata | output | 32 | Control register read value |
| stat_rdata | output | 32 | Status register read value |
| stg_start | output | 7 | One-cycle start pulse per stage |
| stg_abort | output | 7 | One-cycle stop-and-reset pulse per stage |
| stg_done | input | 7 | One-cycle completion pulse per stage |
| pwm_load | input | 1 | One-cycle pulse when the last stage has reloaded the PWM registers |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that done and PWM-load inputs are single-cycle pulses and that a stage reports done only after it has been started. A stray done is tolerated by the logic, but its effects are checked only through the bench. In the bench, each stage's done pulse comes from a responder that waits a fixed latency per stage after the start pulse and forgets the job on abort. `pwm_load` follows the last stage's done by one cycle. Out-of-protocol events (stray dones, a done that lands on a clearing write) are injected by hand at chosen cycles so that each priority rule can be observed on its own.

// File: rtl/foc_seq_pkg.sv
package foc_seq_pkg;
  localparam int NSTG      = 7;
  localparam int REG_W     = 32;
  localparam int AUTO_BASE = 8;   // auto bit of stage i sits at AUTO_BASE+i
  localparam int ATCLR_BIT = 16;
  localparam int SVDIS_BIT = 17;
  localparam int IE_BASE   = 24;
  localparam int GIE_BIT   = 31;

  typedef struct packed {
    logic            gie;
    logic [NSTG-1:0] ie;
    logic            svdis;
    logic            atclr;
    logic [NSTG-1:1] auto_en;
  } seq_cfg_t;
endpackage

// File: rtl/foc_seq_cfg.sv
module foc_seq_cfg
  import foc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl_i,
  input  logic [REG_W-1:0] wdata_i,
  output seq_cfg_t         cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  seq_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    for (int i = 1; i < NSTG; i++) cfg_d.auto_en[i] = wdata_i[AUTO_BASE+i];
    cfg_d.atclr = wdata_i[ATCLR_BIT];
    cfg_d.svdis = wdata_i[SVDIS_BIT];
    for (int i = 0; i < NSTG; i++) cfg_d.ie[i] = wdata_i[IE_BASE+i];
    cfg_d.gie   = wdata_i[GIE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '0;
    else if (wr_ctrl_i) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 1; i < NSTG; i++) rdata_o[AUTO_BASE+i] = cfg_q.auto_en[i];
    rdata_o[ATCLR_BIT] = cfg_q.atclr;
    rdata_o[SVDIS_BIT] = cfg_q.svdis;
    for (int i = 0; i < NSTG; i++) rdata_o[IE_BASE+i] = cfg_q.ie[i];
    rdata_o[GIE_BIT]   = cfg_q.gie;
  end

  assign cfg_o = cfg_q;

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl_i |=> $stable(rdata_o));
endmodule

// File: rtl/foc_seq_slot.sv
module foc_seq_slot #(
  parameter bit HAS_AUTO = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic blocked_i,
  input  logic sw_wr_i,
  input  logic sw_go_i,
  input  logic clr_wr_i,
  input  logic clr_bit_i,
  input  logic auto_i,
  input  logic prev_acc_i,
  input  logic done_i,
  input  logic pwm_load_i,
  input  logic atclr_i,
  output logic start_o,
  output logic abort_o,
  output logic flag_o,
  output logic acc_o
);
  logic run_q, run_d;
  logic flag_q, flag_d;
  logic start_q, abort_q;
  logic acc, trig, abort_now, clr;

  always_comb begin
    acc       = done_i & run_q;
    trig      = ~blocked_i & ((sw_wr_i & sw_go_i) | (HAS_AUTO & auto_i & prev_acc_i));
    abort_now = sw_wr_i & ~sw_go_i & run_q & ~acc & ~trig;
    clr       = (clr_wr_i & clr_bit_i) | (HAS_AUTO & atclr_i & auto_i & pwm_load_i);
    if (trig)                  run_d = 1'b1;
    else if (acc || abort_now) run_d = 1'b0;
    else                       run_d = run_q;
    if (acc)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      flag_q  <= flag_d;
      start_q <= trig;
      abort_q <= abort_now;
    end
  end

  assign start_o = start_q;
  assign abort_o = abort_q;
  assign flag_o  = flag_q;
  assign acc_o   = acc;

  // R4
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> flag_q);
  // R4
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(done_i));
  // R3
  abort_not_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> (!start_q && !run_q));
  // R9
  blocked_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_i |=> !start_q);
  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_wr_i && !pwm_load_i) |=> flag_q);
  // R8
  autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_AUTO && atclr_i && auto_i && pwm_load_i && !done_i) |=> !flag_q);
endmodule

// File: rtl/foc_seq_ctrl.sv
module foc_seq_ctrl
  import foc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] ctrl_rdata,
  output logic [REG_W-1:0] stat_rdata,
  output logic [NSTG-1:0]  stg_start,
  output logic [NSTG-1:0]  stg_abort,
  input  logic [NSTG-1:0]  stg_done,
  input  logic             pwm_load,
  output logic             irq
);
  seq_cfg_t        cfg;
  logic            wr_ctrl, wr_stat;
  logic [NSTG-1:0] flags, acc;

  assign wr_ctrl = reg_we & ~reg_sel;
  assign wr_stat = reg_we &  reg_sel;

  foc_seq_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (reg_wdata),
    .cfg_o     (cfg),
    .rdata_o   (ctrl_rdata)
  );

  generate
    for (genvar i = 0; i < NSTG; i++) begin : g_stage
      logic auto_b, prev_b, blk_b;
      if (i == 0) begin : g_head
        assign auto_b = 1'b0;
        assign prev_b = 1'b0;
      end else begin : g_chain
        assign auto_b = cfg.auto_en[i];
        assign prev_b = acc[i-1];
      end
      if (i == NSTG-1) begin : g_last
        assign blk_b = cfg.svdis;
      end else begin : g_mid
        assign blk_b = 1'b0;
      end
      foc_seq_slot #(.HAS_AUTO(i != 0)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .blocked_i  (blk_b),
        .sw_wr_i    (wr_ctrl),
        .sw_go_i    (reg_wdata[i]),
        .clr_wr_i   (wr_stat),
        .clr_bit_i  (reg_wdata[i]),
        .auto_i     (auto_b),
        .prev_acc_i (prev_b),
        .done_i     (stg_done[i]),
        .pwm_load_i (pwm_load),
        .atclr_i    (cfg.atclr),
        .start_o    (stg_start[i]),
        .abort_o    (stg_abort[i]),
        .flag_o     (flags[i]),
        .acc_o      (acc[i])
      );
    end
  endgenerate

  always_comb begin
    stat_rdata            = '0;
    stat_rdata[NSTG-1:0]  = flags;
  end

  assign irq = cfg.gie & |(flags & cfg.ie);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_rdata != '0));
  // R2
  start_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[NSTG-1:0] == '0);
  // R2
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_start[0] && !reg_we) |=> !stg_start[0]);
endmodule

// File: tb/sim_foc_seq_ctrl.sv
module sim_foc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_rdata, stat_rdata;
  logic [6:0]  stg_start, stg_abort;
  logic [6:0]  tb_done = '0, resp_done = '0;
  logic        tb_pwm = 1'b0, resp_pwm = 1'b0;
  logic        irq;

  int checks = 0, errors = 0, cyc = 0;
  bit chk_on = 0, ended = 0, resp_en = 1;
  int lat [NS] = '{3, 2, 4, 2, 3, 2, 3};
  int cnt [NS] = '{0, 0, 0, 0, 0, 0, 0};

  // reference state
  logic [6:0] m_run, m_flag, m_start, m_abort, m_auto, m_ie;
  logic       m_atclr, m_svdis, m_gie;

  always #(CLK_PERIOD/2) clk = ~clk;

  foc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata),
    .stg_start(stg_start), .stg_abort(stg_abort),
    .stg_done(tb_done | resp_done), .pwm_load(tb_pwm | resp_pwm), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] v = '0;
    for (int i = 1; i < NS; i++) v[8+i] = m_auto[i];
    v[16] = m_atclr;
    v[17] = m_svdis;
    for (int i = 0; i < NS; i++) v[24+i] = m_ie[i];
    v[31] = m_gie;
    return v;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = '0; m_flag = '0; m_start = '0; m_abort = '0;
      m_auto = '0; m_ie = '0; m_atclr = 0; m_svdis = 0; m_gie = 0;
    end else begin : step
      logic [6:0] dn, acc, trig, ab, nrun, nflag;
      bit wc, ws, pw, blk, clr;
      dn = tb_done | resp_done;
      pw = tb_pwm | resp_pwm;
      wc = reg_we && !reg_sel;
      ws = reg_we && reg_sel;
      for (int i = 0; i < NS; i++) acc[i] = dn[i] && m_run[i];
      for (int i = 0; i < NS; i++) begin
        blk = (i == NS-1) && m_svdis;
        trig[i] = !blk && wc && reg_wdata[i];
        if (i > 0 && !blk && m_auto[i] && acc[i-1]) trig[i] = 1;
        ab[i] = wc && !reg_wdata[i] && m_run[i] && !acc[i] && !trig[i];
        nrun[i] = trig[i] ? 1'b1 : ((acc[i] || ab[i]) ? 1'b0 : m_run[i]);
        clr = (ws && reg_wdata[i]) || (i > 0 && m_atclr && m_auto[i] && pw);
        nflag[i] = acc[i] ? 1'b1 : (clr ? 1'b0 : m_flag[i]);
      end
      m_run = nrun; m_flag = nflag; m_start = trig; m_abort = ab;
      if (wc) begin
        for (int i = 1; i < NS; i++) m_auto[i] = reg_wdata[8+i];
        m_auto[0] = 0;
        m_atclr = reg_wdata[16];
        m_svdis = reg_wdata[17];
        for (int i = 0; i < NS; i++) m_ie[i] = reg_wdata[24+i];
        m_gie = reg_wdata[31];
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (chk_on) begin
      chk("R2 R5 R9 start pulses", {25'b0, stg_start}, {25'b0, m_start});
      chk("R3 abort pulses", {25'b0, stg_abort}, {25'b0, m_abort});
      chk("R4 R7 R8 flags", stat_rdata, {25'b0, m_flag});
      chk("R10 irq", {31'b0, irq}, {31'b0, m_gie & |(m_flag & m_ie)});
      chk("R11 control readback", ctrl_rdata, exp_ctrl());
    end
  end

  // stage responder: done after a fixed latency, pwm_load one cycle after last stage
  always @(negedge clk) begin
    #2;
    resp_pwm = resp_en && resp_done[6];
    resp_done = '0;
    if (resp_en) begin
      for (int i = 0; i < NS; i++) begin
        if (stg_abort[i]) cnt[i] = 0;
        else if (stg_start[i]) cnt[i] = lat[i];
        else if (cnt[i] > 0) begin
          cnt[i]--;
          if (cnt[i] == 0) resp_done[i] = 1'b1;
        end
      end
    end
  end

  task automatic drive(input bit we, input bit sel, input logic [31:0] wd,
                       input logic [6:0] dn, input bit pw);
    @(negedge clk); #1;
    reg_we = we; reg_sel = sel; reg_wdata = wd; tb_done = dn; tb_pwm = pw;
    @(negedge clk); #1;
    reg_we = 0; reg_sel = 0; reg_wdata = '0; tb_done = '0; tb_pwm = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    chk_on = 1;
    idle(3);
    // R1: reset state
    chk("R1 reset ctrl", ctrl_rdata, 32'h0);
    chk("R1 reset status", stat_rdata, 32'h0);
    chk("R1 reset pulses", {18'b0, stg_start, stg_abort}, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(2);

    // R2 software start of stage 0, R4 completion, R6 no chain without auto
    drive(1, 0, 32'h0000_0001, '0, 0);
    idle(8);
    chk("R4 R6 only stage 0 flagged", stat_rdata, 32'h1);

    // R4 stray done for idle stage 3 ignored
    drive(0, 0, 32'h0, 7'h08, 0);
    idle(2);
    chk("R4 stray done ignored", stat_rdata, 32'h1);

    // R7 writing zeros keeps, writing one clears
    drive(1, 1, 32'h0000_0000, '0, 0);
    chk("R7 zero write keeps flag", stat_rdata, 32'h1);
    drive(1, 1, 32'h0000_0001, '0, 0);
    chk("R7 w1c clears flag", stat_rdata, 32'h0);

    // R5 R8 R10 full auto chain with auto clear and interrupts
    drive(1, 0, 32'hFF01_7E01, '0, 0);
    idle(40);
    chk("R8 autoclear keeps stage 0 only", stat_rdata, 32'h1);
    chk("R10 irq from stage 0 flag", {31'b0, irq}, 32'h1);
    chk("R11 readback of config", ctrl_rdata, 32'hFF01_7E00);

    // R10 global enable gates irq
    drive(1, 0, 32'h7F01_7E00, '0, 0);
    chk("R10 irq gated by global enable", {31'b0, irq}, 32'h0);
    drive(1, 1, 32'h0000_007F, '0, 0);

    // R3 abort a running stage, then stray done ignored
    drive(1, 0, 32'h7F01_7E01, '0, 0);
    drive(1, 0, 32'h7F01_7E00, '0, 0);
    idle(6);
    chk("R3 aborted stage leaves no flag", stat_rdata, 32'h0);
    drive(0, 0, 32'h0, 7'h01, 0);
    idle(2);
    chk("R3 done after abort ignored", stat_rdata, 32'h0);

    // R9 SVPWM disabled: chain stops before stage 6
    drive(1, 0, 32'h7F03_7E01, '0, 0);
    idle(30);
    chk("R9 stage 6 never completes", stat_rdata, 32'h3F);
    drive(1, 0, 32'h7F03_7E40, '0, 0);
    idle(6);
    chk("R9 software start of stage 6 ignored", stat_rdata, 32'h3F);

    // R7 hardware set wins over simultaneous clear
    resp_en = 0;
    drive(1, 1, 32'h0000_007F, '0, 0);
    drive(1, 0, 32'h0000_0004, '0, 0);
    idle(1);
    drive(1, 1, 32'h0000_0004, 7'h04, 0);
    chk("R7 set wins over clear", stat_rdata, 32'h4);

    // R8 pwm_load with auto clear off leaves flags
    drive(1, 0, 32'h0000_7E00, '0, 0);
    drive(0, 0, 32'h0, '0, 1);
    chk("R8 no autoclear when disabled", stat_rdata, 32'h4);

    idle(3);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule